// File: doc/BRIEF.md
# Video Path Bring-Up Sequencer

This block switches on the video path once the link is trained. A single-cycle start pulse begins a sequence. If the transmit PLL is not locked at that moment, the sequence stops at once with a fault. If it is locked, the block checks the incoming stream-clock status at a slow, fixed interval until that status reports good. It then raises the video enable, which together clears mute, selects capture-timed slave operation and opens the video input.

With the enable high, the block samples the stream-on status at a second, longer interval. It declares the path up only after a run of consecutive good samples that is longer than `GOOD_RUN`. A bad sample anywhere in the run sets the run length back to zero. Each of the two waiting phases has its own budget of `MAX_POLLS` samples. If a phase uses up its budget, the block ends in a timeout.

Both sampling intervals are counted in units of one shared prescaler tick of `TICK_DIV` clock cycles. The final status (up, timeout or PLL fault) stays set until the next accepted start pulse. All pins are plain control and status levels, so there is no stream interface and no back-pressure.

Top module: `video_bringup_seq`

## Requirements
- R1: A start pulse taken while `pll_locked` is low sets `pll_fault` in the next cycle; no sampling follows and `vid_enable` stays low.
- R2: After a start with the PLL locked, `clk_ok` is sampled once every `TICK_DIV*CLK_POLL_TICKS` cycles. If the k-th sample is the first good one, `vid_enable` rises exactly `1 + k*TICK_DIV*CLK_POLL_TICKS` cycles after the start cycle.
- R3: If none of `MAX_POLLS` clock samples is good, `seq_timeout` is set one cycle after the last sample, and `vid_enable` never rises.
- R4: `vid_enable` is high during stream qualification and stays high after success; it is low in the idle, timeout and PLL-fault states.
- R5: `stream_on` is sampled every `TICK_DIV*ON_POLL_TICKS` cycles from the rise of `vid_enable`. `seq_done` rises one cycle after the sample that completes `GOOD_RUN+1` consecutive good samples.
- R6: A low `stream_on` sample sets the consecutive-good count back to zero.
- R7: If `MAX_POLLS` stream samples pass without success, `seq_timeout` is set and `vid_enable` drops. A run that completes on the final allowed sample counts as success.
- R8: `seq_done`, `seq_timeout` and `pll_fault` are mutually exclusive. Each stays set, whatever the inputs do, until the next start pulse, which clears it.
- R9: A start pulse that arrives while a sequence is running has no effect on that sequence.
- R10: `pll_locked` is looked at only when a start is accepted; losing lock later does not change the outcome.
- R11: After reset all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a bring-up sequence when none is running |
| pll_locked | input | 1 | Transmit PLL lock status |
| clk_ok | input | 1 | Incoming stream clock detected |
| stream_on | input | 1 | Video stream running status |
| vid_enable | output | 1 | Clears mute, selects capture timing and enables video input |
| seq_done | output | 1 | Sticky: video path declared up |
| seq_timeout | output | 1 | Sticky: a phase ran out of samples |
| pll_fault | output | 1 | Sticky: PLL unlocked at start |

## Verification
The bound checker watches, on every cycle, that at most one status is set and that none of them clears without a start. It also checks that an error never coexists with the video enable and that success implies the enable. Every rise of an output must be justified by the input sampled just before it: the enable by a good clock status, success by a good stream status, and a fault by a start with lock low. Only the bench scenarios can show the exact sample spacing, the length of the good run needed, the reset of the run on a bad sample, the per-phase sample budgets, success on the last allowed sample, and that mid-run starts and later loss of lock have no effect.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CLKWAIT  = 3'd1,
    ST_QUALIFY  = 3'd2,
    ST_UP       = 3'd3,
    ST_TIMEOUT  = 3'd4,
    ST_PLLERR   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/vbs_prescaler.sv
// Shared cycle divider: one tick every DIV cycles while enabled.
module vbs_prescaler #(
  parameter int unsigned DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (en)      cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/vbs_poll_timer.sv
// Counts prescaler ticks; emits a sample strobe at the interval of the active phase.
module vbs_poll_timer #(
  parameter int unsigned CLK_ITV = 2,
  parameter int unsigned ON_ITV  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic sel_on,
  output logic strobe
);
  localparam int unsigned MAXI = (CLK_ITV > ON_ITV) ? CLK_ITV : ON_ITV;
  localparam int unsigned W    = (MAXI > 1) ? $clog2(MAXI) : 1;
  localparam logic [W-1:0] LIM_CLK = W'(CLK_ITV - 1);
  localparam logic [W-1:0] LIM_ON  = W'(ON_ITV - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;

  assign lim    = sel_on ? LIM_ON : LIM_CLK;
  assign strobe = tick && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (tick)  cnt_q <= strobe ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/vbs_poll_budget.sv
// Counts samples within a phase; flags the sample that uses up the budget.
module vbs_poll_budget #(
  parameter int unsigned MAX_POLLS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic strobe,
  output logic last
);
  localparam int unsigned W = $clog2(MAX_POLLS + 1);
  localparam logic [W-1:0] FINAL = W'(MAX_POLLS - 1);

  logic [W-1:0] cnt_q;

  assign last = strobe && (cnt_q == FINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (strobe && !last)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vbs_run_counter.sv
// Consecutive-good sample counter; hit marks the sample that completes the run.
module vbs_run_counter #(
  parameter int unsigned GOOD_RUN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic strobe,
  input  logic good,
  output logic hit
);
  localparam int unsigned W = $clog2(GOOD_RUN + 2);
  localparam logic [W-1:0] NEED = W'(GOOD_RUN);

  logic [W-1:0] run_q;

  assign hit = strobe && good && (run_q == NEED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (clr)     run_q <= '0;
    else if (strobe) begin
      if (!good)      run_q <= '0;
      else if (!hit)  run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/video_bringup_seq.sv
module video_bringup_seq #(
  parameter int unsigned TICK_DIV       = 250,
  parameter int unsigned CLK_POLL_TICKS = 2,
  parameter int unsigned ON_POLL_TICKS  = 1000,
  parameter int unsigned MAX_POLLS      = 1000,
  parameter int unsigned GOOD_RUN       = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pll_locked,
  input  logic clk_ok,
  input  logic stream_on,
  output logic vid_enable,
  output logic seq_done,
  output logic seq_timeout,
  output logic pll_fault
);
  import vbs_pkg::*;

  seq_state_e state_q, state_d;
  logic running, in_qualify, restart;
  logic tick, strobe, last, hit;

  assign running    = (state_q == ST_CLKWAIT) || (state_q == ST_QUALIFY);
  assign in_qualify = (state_q == ST_QUALIFY);
  assign restart    = (state_d != state_q);

  vbs_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(restart), .en(running), .tick(tick)
  );

  vbs_poll_timer #(.CLK_ITV(CLK_POLL_TICKS), .ON_ITV(ON_POLL_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(restart), .tick(tick),
    .sel_on(in_qualify), .strobe(strobe)
  );

  vbs_poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk(clk), .rst_n(rst_n), .clr(restart), .strobe(strobe), .last(last)
  );

  vbs_run_counter #(.GOOD_RUN(GOOD_RUN)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(restart), .strobe(strobe && in_qualify),
    .good(stream_on), .hit(hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_UP, ST_TIMEOUT, ST_PLLERR: begin
        if (start) state_d = pll_locked ? ST_CLKWAIT : ST_PLLERR;
      end
      ST_CLKWAIT: begin
        if (strobe) begin
          if (clk_ok)    state_d = ST_QUALIFY;
          else if (last) state_d = ST_TIMEOUT;
        end
      end
      ST_QUALIFY: begin
        if (hit)       state_d = ST_UP;
        else if (last) state_d = ST_TIMEOUT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      vid_enable  <= 1'b0;
      seq_done    <= 1'b0;
      seq_timeout <= 1'b0;
      pll_fault   <= 1'b0;
    end else begin
      state_q     <= state_d;
      vid_enable  <= (state_d == ST_QUALIFY) || (state_d == ST_UP);
      seq_done    <= (state_d == ST_UP);
      seq_timeout <= (state_d == ST_TIMEOUT);
      pll_fault   <= (state_d == ST_PLLERR);
    end
  end
endmodule

// File: rtl/video_bringup_seq_chk.sv
module video_bringup_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic pll_locked,
  input logic clk_ok,
  input logic stream_on,
  input logic vid_enable,
  input logic seq_done,
  input logic seq_timeout,
  input logic pll_fault
);
  p_one_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_done, seq_timeout, pll_fault}));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !start) |=> seq_done);

  p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_timeout && !start) |=> seq_timeout);

  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_fault && !start) |=> pll_fault);

  p_err_no_video_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_timeout || pll_fault) |-> !vid_enable);

  p_done_video_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> vid_enable);

  p_fault_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_fault) |-> ($past(start) && !$past(pll_locked)));

  p_video_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vid_enable) |-> $past(clk_ok));

  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> $past(stream_on));
endmodule

bind video_bringup_seq video_bringup_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pll_locked(pll_locked),
  .clk_ok(clk_ok), .stream_on(stream_on), .vid_enable(vid_enable),
  .seq_done(seq_done), .seq_timeout(seq_timeout), .pll_fault(pll_fault)
);

// File: tb/tb_video_bringup_seq.sv
`timescale 1ns/1ps
module tb_video_bringup_seq;
  localparam int TD = 4;
  localparam int CI = 2;
  localparam int OI = 5;
  localparam int MP = 20;
  localparam int GR = 3;
  localparam int P1 = TD * CI;
  localparam int P2 = TD * OI;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pll_locked = 1'b0, clk_ok = 1'b0, stream_on = 1'b0;
  logic vid_enable, seq_done, seq_timeout, pll_fault;

  always #2 clk = ~clk;

  video_bringup_seq #(
    .TICK_DIV(TD), .CLK_POLL_TICKS(CI), .ON_POLL_TICKS(OI),
    .MAX_POLLS(MP), .GOOD_RUN(GR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_locked(pll_locked),
    .clk_ok(clk_ok), .stream_on(stream_on), .vid_enable(vid_enable),
    .seq_done(seq_done), .seq_timeout(seq_timeout), .pll_fault(pll_fault)
  );

  // kind: 0 success, 1 timeout, 2 pll fault
  typedef struct {
    int    kind;
    int    n1;
    int    n2;
    string tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Driver: computes the expected outcome, queues it, then drives one sequence.
  task automatic run_seq(input bit pll, input int k1, input logic [31:0] pat,
                         input bit drop_pll, input int restart_at, input string tag);
    exp_t e;
    int run;
    int j;
    e.tag = tag;
    if (!pll) begin
      e.kind = 2; e.n1 = -1; e.n2 = 1;
    end else if (k1 < 1 || k1 > MP) begin
      e.kind = 1; e.n1 = -1; e.n2 = 1 + MP * P1;
    end else begin
      e.n1 = 1 + k1 * P1;
      run = 0;
      e.kind = 1; e.n2 = e.n1 + MP * P2;
      for (int k = 1; k <= MP; k++) begin
        run = pat[k-1] ? run + 1 : 0;
        if (run == GR + 1) begin
          e.kind = 0; e.n2 = e.n1 + k * P2;
          break;
        end
      end
    end
    q.push_back(e);

    @(negedge clk);
    start = 1'b1; pll_locked = pll; clk_ok = 1'b0; stream_on = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (drop_pll) pll_locked = 1'b0;
    j = 0;
    while (!vid_enable && !(seq_done || seq_timeout || pll_fault)) begin
      clk_ok = (k1 >= 1) && ((j / P1) >= k1 - 1);
      @(negedge clk);
      j++;
    end
    j = 0;
    while (!(seq_done || seq_timeout || pll_fault)) begin
      stream_on = ((j / P2) < 32) ? pat[j / P2] : 1'b0;
      clk_ok    = 1'b0;
      start     = (j == restart_at);
      @(negedge clk);
      j++;
    end
    start = 1'b0; stream_on = 1'b0; clk_ok = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: measures each sequence at the ports and compares with the queue.
  initial begin
    bit tracking = 0;
    int n = 0;
    int n1 = -1;
    int kind;
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (!tracking) begin
        if (rst_n && start) begin
          tracking = 1; n = 0; n1 = -1;
        end
      end else begin
        n++;
        if (vid_enable && n1 < 0) n1 = n;
        if (seq_done || seq_timeout || pll_fault) begin
          kind = seq_done ? 0 : (seq_timeout ? 1 : 2);
          if (q.size() == 0) begin
            check(1'b0, "R8", "unexpected outcome", kind, -1);
          end else begin
            e = q.pop_front();
            check(kind == e.kind, e.tag, "outcome kind", kind, e.kind);
            check(n1 == e.n1, "R2", "cycles to vid_enable", n1, e.n1);
            check(n == e.n2, e.tag, "cycles to outcome", n, e.n2);
            check(vid_enable == (e.kind == 0), "R4", "vid_enable at outcome",
                  int'(vid_enable), int'(e.kind == 0));
          end
          tracking = 0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: all outputs low after reset
    check({vid_enable, seq_done, seq_timeout, pll_fault} == 4'b0, "R11",
          "outputs after reset", int'({vid_enable, seq_done, seq_timeout, pll_fault}), 0);

    // R1: PLL unlocked at start
    run_seq(1'b0, 1, 32'hFFFF_FFFF, 1'b0, -1, "R1");
    // R5: clock good at first sample, stream always good
    run_seq(1'b1, 1, 32'hFFFF_FFFF, 1'b0, -1, "R5");

    // R8: success is sticky while inputs move and no start arrives
    held = 1'b1;
    for (int i = 0; i < 40; i++) begin
      stream_on = i[0]; clk_ok = ~i[0]; pll_locked = i[1];
      @(negedge clk);
      if (!(seq_done && vid_enable && !seq_timeout)) held = 1'b0;
    end
    stream_on = 1'b0; clk_ok = 1'b0;
    check(held, "R8", "done held without start", int'(held), 1);

    // R6: good,good,bad,good x4 -> run restarts, success on sample 7
    run_seq(1'b1, 3, 32'h0000_007B, 1'b0, -1, "R6");
    // R7: runs of three good never complete -> stream-phase timeout
    run_seq(1'b1, 2, 32'h7777_7777, 1'b0, -1, "R7");
    // R3: clock never good -> clock-phase timeout
    run_seq(1'b1, 0, 32'hFFFF_FFFF, 1'b0, -1, "R3");
    // R7: clock good on the last allowed sample, run done on the last stream sample
    run_seq(1'b1, MP, 32'h000F_0000, 1'b0, -1, "R7");
    // R9 and R10: lock lost after start, extra start mid-qualification
    run_seq(1'b1, 1, 32'hFFFF_FFFF, 1'b1, 30, "R9_R10");
    // R8: start from a success state into a PLL fault clears done
    run_seq(1'b0, 1, 32'h0, 1'b0, -1, "R8");

    repeat (5) @(negedge clk);
    check(q.size() == 0, "R8", "outcomes left unobserved", q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule